// File: doc/BRIEF.md
# Chip-Select Bus Cycle Controller

This block runs external memory read and write cycles for a single chip-select region. A requester presents an address, write data, a direction flag and per-byte lane enables. When the controller is idle it takes the request and drives an external cycle. The external signals are the address, the data output with its own output enable, an active-low chip select, an active-low output enable, a read/write line and four active-low byte strobes. When the cycle ends, the controller gives the requester a one-clock done pulse, together with read data when the access was a read.

Each cycle has two base phases, C1 and C2. Wait states, if any, follow C2. A 5-bit wait field sets how many wait states the cycle has. The all-ones value of that field is special: it hands the end of the cycle to an active-low external acknowledge input, and such a cycle always has at least one wait state. A 2-bit bus-type code chooses how the strobes behave. Code 00 is for wide memories, where the strobes act as byte enables on both reads and writes. Code 01 is for 8-bit memories, where the strobes act only as write enables. Codes 10 and 11 are treated as illegal. The wait field and the bus-type code sit in a small configuration register. Each cycle takes a snapshot of both when its request is accepted.

Top module: `csel_cycle_ctrl`

## Requirements
- R1: A request (req_valid high) is accepted only on a clock edge where `idle` is high, and `idle` is low while a cycle is in progress. Requests presented while the block is busy are ignored.
- R2: With a wait field N from 0 to 30, `bus_cs_n` stays low for exactly N+2 consecutive clocks (C1, C2, then N wait states). `rsp_done` is high in the clock that follows the last of them.
- R3: With the wait field at 31, the cycle ends at the first edge after C2 where `bus_ta_n` is sampled low. `bus_ta_n` low during C1 or C2 has no effect, so the cycle has at least three clocks.
- R4: With any wait field other than 31, `bus_ta_n` has no effect on the length of the cycle.
- R5: On a read, `bus_rw` is 1, `bus_oe_n` is 0 and `bus_doe` is 0 for the whole cycle. On a write, `bus_rw` is 0, `bus_doe` is 1 and `bus_oe_n` is 1. Outside a cycle, `bus_rw` is 1, `bus_doe` is 0 and `bus_oe_n` is 1.
- R6: With bus type 00, `bus_bs_n[i]` is low during the cycle exactly when `req_be[i]` was 1, on both reads and writes.
- R7: With bus type 01, `bus_bs_n` equals the inverted `req_be` during writes and stays 4'b1111 during reads.
- R8: With bus type 10 or 11, a request gives `rsp_done` and `rsp_err` both high in the clock after acceptance. `bus_cs_n` and the strobes stay inactive.
- R9: On a read, `rsp_rdata` holds the value of `bus_din` sampled at the closing edge of the last bus clock, and it is valid while `rsp_done` is high. `rsp_done` lasts one clock, and `rsp_err` is low for legal cycles.
- R10: After reset, the bus type is 00 and the wait field is 0. `bus_cs_n`, `bus_oe_n` and `bus_bs_n` are all ones, `rsp_done` is low and `idle` is high.
- R11: When `cfg_load` is high at an edge, the register takes `cfg_type` and `cfg_wait`. A cycle already in progress keeps the values it captured at acceptance.
- R12: During a cycle, `bus_addr`, and on a write `bus_dout`, equal the accepted request and stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Loads the configuration register |
| cfg_type | input | 2 | Bus-type code: 00 wide, 01 8-bit, 10/11 illegal |
| cfg_wait | input | WS_W | Wait-state count; all ones selects external acknowledge |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | LANES | Byte lane enables |
| idle | output | 1 | Controller idle, can accept a request |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Completion was for an illegal bus type |
| rsp_rdata | output | DATA_W | Read data |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DATA_W | External read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_bs_n | output | LANES | Byte strobes, active low |
| bus_ta_n | input | 1 | External transfer acknowledge, active low |

## Verification
Chip select and the strobes change one clock after the accepting edge. The done pulse comes one clock after the final bus clock, which gives N+3 clocks from acceptance with internal waits. In acknowledge mode it comes one clock after the first wait clock in which the acknowledge is low. An illegal request completes one clock after acceptance. The bench keeps a behavioural model that is stepped on the same rising edge the design uses, and compares every output at the falling edge. All inputs, including the acknowledge, are driven at or after the falling edge. Cycle lengths are also measured from chip select and compared with the expected count for each wait setting.

// File: rtl/csel_pkg.sv
package csel_pkg;
   typedef enum logic [1:0] {
      BT_WIDE = 2'b00,
      BT_BYTE = 2'b01,
      BT_RSVD = 2'b10,
      BT_DRAM = 2'b11
   } bus_type_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_C1,
      ST_C2,
      ST_WAIT
   } cyc_state_e;
endpackage

// File: rtl/csel_cfg_reg.sv
module csel_cfg_reg
   import csel_pkg::*;
#(
   parameter int WS_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [1:0]      type_in,
   input  logic [WS_W-1:0] wait_in,
   output bus_type_e       type_q,
   output logic [WS_W-1:0] wait_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         type_q <= BT_WIDE;
         wait_q <= '0;
      end else if (load) begin
         type_q <= bus_type_e'(type_in);
         wait_q <= wait_in;
      end
   end
endmodule

// File: rtl/csel_wait_timer.sv
module csel_wait_timer #(
   parameter int WS_W       = 5,
   parameter bit EXT_ACK_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_c2,
   input  logic            in_wait,
   input  logic [WS_W-1:0] ws,
   input  logic            ta_n,
   output logic            ext_mode,
   output logic            last
);
   logic [WS_W-1:0] rem;

   generate
      if (EXT_ACK_EN) begin : g_ext
         assign ext_mode = &ws;
      end else begin : g_count_only
         assign ext_mode = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem <= '0;
      end else if (in_c2) begin
         rem <= ws;
      end else if (in_wait && !ext_mode) begin
         rem <= rem - 1'b1;
      end
   end

   always_comb begin
      last = 1'b0;
      if (in_c2) begin
         last = !ext_mode && (ws == '0);
      end else if (in_wait) begin
         last = ext_mode ? !ta_n : (rem == {{(WS_W-1){1'b0}}, 1'b1});
      end
   end

   // an internally counted wait never runs with an exhausted count
   assert_wait_count_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && !ext_mode) |-> (rem != '0));
endmodule

// File: rtl/csel_strobe_gen.sv
module csel_strobe_gen
   import csel_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             active,
   input  logic             is_write,
   input  bus_type_e        btype,
   input  logic [LANES-1:0] be,
   output logic             cs_n,
   output logic             oe_n,
   output logic             rw,
   output logic             doe,
   output logic [LANES-1:0] bs_n
);
   logic lane_gate;

   assign cs_n      = !active;
   assign oe_n      = !(active && !is_write);
   assign rw        = !(active && is_write);
   assign doe       = active && is_write;
   assign lane_gate = active && (is_write || (btype == BT_WIDE));

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign bs_n[i] = !(lane_gate && be[i]);
      end
   endgenerate
endmodule

// File: rtl/csel_cycle_ctrl.sv
module csel_cycle_ctrl
   import csel_pkg::*;
#(
   parameter int ADDR_W     = 23,
   parameter int DATA_W     = 32,
   parameter int LANES      = DATA_W / 8,
   parameter int WS_W       = 5,
   parameter bit EXT_ACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [1:0]        cfg_type,
   input  logic [WS_W-1:0]   cfg_wait,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              idle,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din,
   output logic              bus_cs_n,
   output logic              bus_oe_n,
   output logic              bus_rw,
   output logic [LANES-1:0]  bus_bs_n,
   input  logic              bus_ta_n
);
   generate
      if (DATA_W != 8 * LANES) begin : g_bad_lanes
         $fatal(1, "DATA_W must equal 8*LANES");
      end
      if (WS_W < 2) begin : g_bad_ws
         $fatal(1, "WS_W must be at least 2");
      end
   endgenerate

   cyc_state_e        state;
   bus_type_e         cur_type;
   logic [WS_W-1:0]   cur_wait;
   bus_type_e         q_type;
   logic [WS_W-1:0]   q_ws;
   logic              q_write;
   logic [LANES-1:0]  q_be;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_wdata;
   logic              ext_mode;
   logic              cyc_last;
   logic              cfg_illegal;

   csel_cfg_reg #(.WS_W(WS_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_load),
      .type_in (cfg_type),
      .wait_in (cfg_wait),
      .type_q  (cur_type),
      .wait_q  (cur_wait)
   );

   csel_wait_timer #(.WS_W(WS_W), .EXT_ACK_EN(EXT_ACK_EN)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_c2    (state == ST_C2),
      .in_wait  (state == ST_WAIT),
      .ws       (q_ws),
      .ta_n     (bus_ta_n),
      .ext_mode (ext_mode),
      .last     (cyc_last)
   );

   csel_strobe_gen #(.LANES(LANES)) u_strobe (
      .active   (state != ST_IDLE),
      .is_write (q_write),
      .btype    (q_type),
      .be       (q_be),
      .cs_n     (bus_cs_n),
      .oe_n     (bus_oe_n),
      .rw       (bus_rw),
      .doe      (bus_doe),
      .bs_n     (bus_bs_n)
   );

   assign cfg_illegal = (cur_type == BT_RSVD) || (cur_type == BT_DRAM);
   assign idle        = (state == ST_IDLE);
   assign bus_addr    = q_addr;
   assign bus_dout    = q_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         q_type    <= BT_WIDE;
         q_ws      <= '0;
         q_write   <= 1'b0;
         q_be      <= '0;
         q_addr    <= '0;
         q_wdata   <= '0;
         rsp_done  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_done <= 1'b0;
         rsp_err  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  q_type  <= cur_type;
                  q_ws    <= cur_wait;
                  q_write <= req_write;
                  q_be    <= req_be;
                  q_addr  <= req_addr;
                  q_wdata <= req_wdata;
                  if (cfg_illegal) begin
                     rsp_done <= 1'b1;
                     rsp_err  <= 1'b1;
                  end else begin
                     state <= ST_C1;
                  end
               end
            end
            ST_C1: state <= ST_C2;
            ST_C2, ST_WAIT: begin
               if (cyc_last) begin
                  state    <= ST_IDLE;
                  rsp_done <= 1'b1;
                  if (!q_write) rsp_rdata <= bus_din;
               end else begin
                  state <= ST_WAIT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_n |-> (bus_rw && !bus_cs_n && !bus_doe));

   assert_byte_read_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && q_type == BT_BYTE && bus_rw) |-> (&bus_bs_n));

   assert_illegal_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_done && $past(bus_cs_n) && bus_cs_n));

   assert_ext_min_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !rsp_err && ext_mode) |-> $past(state == ST_WAIT));

   assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_rw)));

   assert_busy_not_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs_n |-> !idle);
endmodule

// File: tb/csel_cycle_ctrl_tb.sv
module csel_cycle_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [1:0]  cfg_type = 2'b00;
   logic [4:0]  cfg_wait = 5'd0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [22:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        idle, rsp_done, rsp_err;
   logic [31:0] rsp_rdata;
   logic [22:0] bus_addr;
   logic [31:0] bus_dout;
   logic        bus_doe;
   logic [31:0] bus_din = 32'h1357_9bdf;
   logic        bus_cs_n, bus_oe_n, bus_rw;
   logic [3:0]  bus_bs_n;
   logic        bus_ta_n = 1'b1;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   csel_cycle_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_type(cfg_type),
      .cfg_wait(cfg_wait), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .idle(idle), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
      .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_rw(bus_rw),
      .bus_bs_n(bus_bs_n), .bus_ta_n(bus_ta_n)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference, stepped on the same edge as the design
   bit          m_active = 0;
   int          m_age = 0;
   bit          m_write = 0;
   logic [3:0]  m_be = 0;
   logic [22:0] m_addr = 0;
   logic [31:0] m_wdata = 0;
   int          m_type = 0;
   int          m_ws = 0;
   int          m_cfg_type = 0;
   int          m_cfg_ws = 0;
   bit          m_done = 0;
   bit          m_err = 0;
   logic [31:0] m_rdata = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 0; m_age = 0; m_cfg_type = 0; m_cfg_ws = 0;
         m_done = 0; m_err = 0; m_rdata = 0;
      end else begin
         bit nd, ne, fin;
         nd = 0; ne = 0;
         if (m_active) begin
            if (m_ws != 31) fin = (m_age == 1 + m_ws);
            else            fin = (m_age >= 2) && !bus_ta_n;
            if (fin) begin
               m_active = 0;
               nd = 1;
               if (!m_write) m_rdata = bus_din;
            end else begin
               m_age++;
            end
         end else if (req_valid) begin
            if (m_cfg_type >= 2) begin
               nd = 1; ne = 1;
            end else begin
               m_active = 1; m_age = 0;
               m_write = req_write; m_be = req_be; m_addr = req_addr;
               m_wdata = req_wdata; m_type = m_cfg_type; m_ws = m_cfg_ws;
            end
         end
         if (cfg_load) begin
            m_cfg_type = int'(cfg_type);
            m_cfg_ws = int'(cfg_wait);
         end
         m_done = nd; m_err = ne;
      end
   end

   // per-clock comparison, cycle length monitor, acknowledge driver, read data source
   int cs_run = 0;
   int last_len = 0;
   int ta_at = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [3:0] ebs;
         ebs = (m_active && (m_write || m_type == 0)) ? ~m_be : 4'hF;
         chk("R1", "idle", idle, !m_active);
         chk("R2", "cs_n", bus_cs_n, !m_active);
         chk("R5", "oe_n", bus_oe_n, !(m_active && !m_write));
         chk("R5", "rw", bus_rw, !(m_active && m_write));
         chk("R5", "doe", bus_doe, m_active && m_write);
         chk((m_type == 1) ? "R7" : "R6", "bs_n", bus_bs_n, ebs);
         chk("R9", "done", rsp_done, m_done);
         chk("R8", "err", rsp_err, m_err);
         if (m_done && !m_err && !m_write) chk("R9", "rdata", rsp_rdata, m_rdata);
         if (m_active) begin
            chk("R12", "addr", bus_addr, m_addr);
            if (m_write) chk("R12", "dout", bus_dout, m_wdata);
         end
      end
      if (!bus_cs_n) cs_run++;
      else if (cs_run != 0) begin
         last_len = cs_run;
         cs_run = 0;
      end
      bus_ta_n = !(!bus_cs_n && cs_run > ta_at);
      bus_din = bus_din * 32'd1103515245 + 32'd12345;
   end

   task automatic set_cfg(input logic [1:0] t, input logic [4:0] w);
      @(negedge clk); #2;
      cfg_load = 1'b1; cfg_type = t; cfg_wait = w;
      @(negedge clk); #2;
      cfg_load = 1'b0;
   endtask

   task automatic xfer(input bit w, input logic [22:0] a, input logic [31:0] d,
                       input logic [3:0] be, input int hold, input int ta_i,
                       input int exp_len, input string tag, input bit mid,
                       input logic [1:0] mt, input logic [4:0] mw);
      @(negedge clk); #2;
      ta_at = ta_i;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk); #2;
      end
      req_valid = 1'b0;
      if (mid) begin
         cfg_load = 1'b1; cfg_type = mt; cfg_wait = mw;
         @(negedge clk); #2;
         cfg_load = 1'b0;
      end
      while (!rsp_done) begin
         @(negedge clk); #2;
      end
      if (exp_len > 0) chk(tag, "cycle_len", last_len, exp_len);
      @(negedge clk); #2;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL R1 watchdog act=hung exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk); #2;
      // R10: reset state at the ports
      chk("R10", "idle", idle, 1);
      chk("R10", "cs_n", bus_cs_n, 1);
      chk("R10", "oe_n", bus_oe_n, 1);
      chk("R10", "bs_n", bus_bs_n, 4'hF);
      chk("R10", "done", rsp_done, 0);
      // R10: reset config is wide type, zero waits -> 2-clock read with strobes
      xfer(0, 23'h00_0010, 0, 4'hF, 1, 0, 2, "R10", 0, 0, 0);

      set_cfg(2'b00, 5'd0);
      xfer(1, 23'h12_3456, 32'hdead_beef, 4'hF, 1, 99, 2, "R2", 0, 0, 0);
      xfer(0, 23'h01_0203, 0, 4'h3, 1, 99, 2, "R6", 0, 0, 0);
      // R1: request held high while busy is ignored
      xfer(1, 23'h2a_aaaa, 32'h0bad_f00d, 4'h6, 2, 99, 2, "R1", 0, 0, 0);

      // R4: acknowledge held low, internal count still decides
      set_cfg(2'b00, 5'd3);
      xfer(0, 23'h00_4444, 0, 4'h8, 1, 0, 5, "R4", 0, 0, 0);
      xfer(1, 23'h00_5555, 32'h1234_5678, 4'hC, 1, 0, 5, "R2", 0, 0, 0);

      // R7: 8-bit mode strobes
      set_cfg(2'b01, 5'd1);
      xfer(1, 23'h00_0001, 32'h0000_00a5, 4'h1, 1, 99, 3, "R7", 0, 0, 0);
      xfer(0, 23'h00_0002, 0, 4'h2, 1, 99, 3, "R7", 0, 0, 0);

      // R3: external acknowledge mode
      set_cfg(2'b00, 5'd31);
      xfer(0, 23'h03_0000, 0, 4'hF, 1, 0, 3, "R3", 0, 0, 0);
      xfer(1, 23'h03_0004, 32'hcafe_0001, 4'h5, 1, 5, 6, "R3", 0, 0, 0);
      xfer(0, 23'h03_0008, 0, 4'hF, 1, 2, 3, "R3", 0, 0, 0);
      set_cfg(2'b01, 5'd31);
      xfer(0, 23'h03_000c, 0, 4'h4, 1, 3, 4, "R3", 0, 0, 0);

      // R8: illegal bus types
      set_cfg(2'b10, 5'd0);
      xfer(0, 23'h04_0000, 0, 4'hF, 1, 99, 0, "R8", 0, 0, 0);
      set_cfg(2'b11, 5'd5);
      xfer(1, 23'h04_0004, 32'h5555_aaaa, 4'hF, 1, 99, 0, "R8", 0, 0, 0);

      // R11: mid-cycle reload does not alter the cycle in progress
      set_cfg(2'b00, 5'd4);
      xfer(0, 23'h05_0000, 0, 4'h9, 1, 0, 6, "R11", 1, 2'b01, 5'd0);
      xfer(0, 23'h05_0004, 0, 4'hF, 1, 0, 2, "R11", 0, 0, 0);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule